// File: doc/BRIEF.md
# Peripheral interrupt vector arbiter

This block sits between a set of peripheral interrupt sources and one request input of a processor's interrupt controller. All peripheral sources share that single core vector. The block latches the rising edge of each peripheral request into a pending bit. It picks the highest priority pending source that is enabled and loads that source's own vector address into a holding register. It then raises the shared interrupt line.

The processor's shared handler reads the holding register and jumps to the address it finds there. The holding register and the shared request stay frozen until that read. The read clears the pending bit of the source that was presented and drops the request. If enabled pending bits remain, the arbiter presents the next one a cycle later.

Top module: `pvec_arbiter`

## Requirements
- R1: While reset is active, and on leaving it, `irq_o` is 0 and `vec_o` is 0x0000.
- R2: A source's pending bit is set only by a 0-to-1 transition of its `req_i` bit. A request held high after service does not raise the interrupt again.
- R3: A request edge driven before clock edge k sets the pending bit at k. If the arbiter is idle, `irq_o` is 1 after edge k+1, and `vec_o` then shows 0x0030 + 4·n for source n.
- R4: When several enabled sources are pending, the lowest-numbered source is presented first, and the others follow in ascending index order.
- R5: While `irq_o` is 1 and no read occurs, `vec_o` and `irq_o` hold their values, even if a higher priority request arrives.
- R6: A read (`vec_rd_i` = 1 at a clock edge while `irq_o` = 1) clears only the presented source's pending bit and drops `irq_o` at that edge. If enabled pending bits remain, `irq_o` rises again at the next edge with the new vector.
- R7: A source whose `en_i` bit is 0 is never presented, but its pending bit is kept. Setting the enable later presents it.
- R8: A read strobe while `irq_o` is 0 is ignored: `vec_o` keeps its last value and no pending bit changes.
- R9: The last source (index 10 with the default of eleven sources) maps to 0x0058.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Peripheral interrupt requests, rising edge sensitive |
| en_i | input | N_SRC | Per-source arbitration enable |
| vec_rd_i | input | 1 | Read strobe for the vector holding register |
| vec_o | output | VEC_W | Vector address of the presented source |
| irq_o | output | 1 | Shared interrupt request to the core |

## Verification
The bench raises several requests in the same cycle and checks that they come out one per read, in ascending index order. A design that encoded priority the wrong way, or that lost a pending bit when another source was served, would put the wrong vector in the queue. It fires a higher priority request while a vector is held. A design that reloaded the holding register without a read would then change `vec_o` under the handler. It also checks three more cases: a request held high after service, which a level-sensitive design would serve again; a masked source that must survive until it is enabled; and a stray read while the arbiter is idle, which must change neither the vector nor any pending bit.

// File: rtl/pvec_pkg.sv
package pvec_pkg;
  function automatic logic [15:0] vec_addr(input logic [15:0] base,
                                           input logic [15:0] step,
                                           input int unsigned idx);
    return base + 16'(step * 16'(idx));
  endfunction
endpackage

// File: rtl/pvec_pend_bit.sv
module pvec_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic req_q;
  logic rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      req_q <= req_i;
      // a fresh edge wins over a clear in the same cycle
      if (rise)       pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pvec_prio.sv
module pvec_prio #(
  parameter int unsigned N     = 11,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vld_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = |vld_i;
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (vld_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pvec_hold.sv
module pvec_hold
  import pvec_pkg::*;
#(
  parameter int unsigned N        = 11,
  parameter int unsigned IDX_W    = $clog2(N),
  parameter int unsigned VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0030,
  parameter logic [15:0] VEC_STEP = 16'h0004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             rd_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N-1:0]     clr_o
);
  logic [IDX_W-1:0] held_q;
  logic             take;

  assign take = irq_o & rd_i;

  always_comb begin
    clr_o = '0;
    if (take) clr_o[held_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      vec_o  <= '0;
      held_q <= '0;
    end else if (irq_o) begin
      if (rd_i) irq_o <= 1'b0;
    end else if (hit_i) begin
      irq_o  <= 1'b1;
      held_q <= idx_i;
      vec_o  <= VEC_W'(vec_addr(VEC_BASE, VEC_STEP, int'(idx_i)));
    end
  end
endmodule

// File: rtl/pvec_arbiter.sv
module pvec_arbiter #(
  parameter int unsigned N_SRC    = 11,
  parameter int unsigned VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0030,
  parameter logic [15:0] VEC_STEP = 16'h0004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             vec_rd_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             irq_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr;
  logic             hit;
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    pvec_pend_bit i_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[g]),
      .clr_i  (clr[g]),
      .pend_o (pend[g])
    );
  end

  pvec_prio #(.N(N_SRC), .IDX_W(IDX_W)) i_prio (
    .vld_i (pend & en_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  pvec_hold #(
    .N(N_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .idx_i  (idx),
    .rd_i   (vec_rd_i),
    .irq_o  (irq_o),
    .vec_o  (vec_o),
    .clr_o  (clr)
  );
endmodule

// File: rtl/pvec_arbiter_chk.sv
module pvec_arbiter_chk #(
  parameter int unsigned N_SRC    = 11,
  parameter int unsigned VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0030,
  parameter logic [15:0] VEC_STEP = 16'h0004
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] en_i,
  input logic             vec_rd_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             irq_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam logic [15:0] VEC_TOP = VEC_BASE + 16'(VEC_STEP * 16'(N_SRC - 1));

  logic [N_SRC-1:0] en_q;
  logic [15:0]      off;
  logic [15:0]      idx_full;
  logic             in_range;
  logic             en_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_i;
  end

  always_comb begin
    off      = 16'(vec_o) - VEC_BASE;
    idx_full = off / VEC_STEP;
    in_range = (16'(vec_o) >= VEC_BASE) && (16'(vec_o) <= VEC_TOP);
    en_hit   = in_range && (idx_full < 16'(N_SRC)) && en_q[idx_full[IDX_W-1:0]];
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_r1: assert (!irq_o && vec_o == '0);
  end

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> in_range && (off % VEC_STEP == 16'd0));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !vec_rd_i |=> irq_o && $stable(vec_o));

  p_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && vec_rd_i |=> !irq_o);

  p_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> en_hit);

  p_idle_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |=> irq_o || $stable(vec_o));

  p_no_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) && !irq_o && $past(req_i == '0) && (en_i == '0) |=> !irq_o);
endmodule

bind pvec_arbiter pvec_arbiter_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .en_i     (en_i),
  .vec_rd_i (vec_rd_i),
  .vec_o    (vec_o),
  .irq_o    (irq_o)
);

// File: tb/test_pvec_arbiter.sv
module test_pvec_arbiter;
  localparam int N = 11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] en_i = '1;
  logic        vec_rd_i = 1'b0;
  logic [15:0] vec_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic        irq_prev = 1'b0;
  bit          done = 0;

  always #2.5 clk_i = ~clk_i;

  pvec_arbiter i_pvec_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .en_i(en_i),
    .vec_rd_i(vec_rd_i), .vec_o(vec_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] vaddr(int n);
    return 16'h0030 + 16'(4 * n);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: each new presentation pops the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && irq_o && !irq_prev) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected vector", int'(vec_o), 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        chk(vec_o == e, "R4 vector order", int'(vec_o), int'(e));
      end
    end
    irq_prev <= irq_o;
  end

  task automatic pulse(logic [N-1:0] m);
    req_i = req_i | m;
    @(negedge clk_i);
    req_i = req_i & ~m;
  endtask

  task automatic do_read();
    vec_rd_i = 1'b1;
    @(negedge clk_i);
    vec_rd_i = 1'b0;
  endtask

  task automatic wait_irq(string req);
    int k = 0;
    while (!irq_o && k < 50) begin @(negedge clk_i); k++; end
    chk(irq_o, req, int'(irq_o), 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    idle(2);
    chk(irq_o == 0, "R1 irq in reset", int'(irq_o), 0);
    chk(vec_o == 0, "R1 vec in reset", int'(vec_o), 0);
    rst_ni = 1'b1;
    idle(2);
    chk(irq_o == 0 && vec_o == 0, "R1 after reset", int'(vec_o), 0);

    // R3 timing, single source
    exp_q.push_back(vaddr(3));
    pulse(11'b1 << 3);
    chk(irq_o == 0, "R3 irq one cycle early", int'(irq_o), 0);
    @(negedge clk_i);
    chk(irq_o == 1, "R3 irq on second edge", int'(irq_o), 1);
    chk(vec_o == 16'h003C, "R3 vector of source 3", int'(vec_o), 16'h003C);
    do_read();
    chk(irq_o == 0, "R6 drop after read", int'(irq_o), 0);
    idle(3);
    chk(irq_o == 0, "R6 nothing left", int'(irq_o), 0);

    // R4 / R6 / R9 simultaneous sources
    exp_q.push_back(vaddr(2));
    exp_q.push_back(vaddr(7));
    exp_q.push_back(vaddr(10));
    pulse((11'b1 << 7) | (11'b1 << 2) | (11'b1 << 10));
    wait_irq("R4 first of three");
    chk(vec_o == 16'h0038, "R4 lowest index first", int'(vec_o), 16'h0038);
    do_read();
    chk(irq_o == 0, "R6 gap after read", int'(irq_o), 0);
    @(negedge clk_i);
    chk(irq_o == 1, "R6 reassert next edge", int'(irq_o), 1);
    chk(vec_o == 16'h004C, "R6 next vector", int'(vec_o), 16'h004C);
    do_read();
    @(negedge clk_i);
    chk(vec_o == 16'h0058, "R9 last source vector", int'(vec_o), 16'h0058);
    do_read();
    idle(2);

    // R5 hold against higher priority arrival
    exp_q.push_back(vaddr(5));
    exp_q.push_back(vaddr(0));
    pulse(11'b1 << 5);
    wait_irq("R5 present source 5");
    pulse(11'b1);
    idle(4);
    chk(irq_o == 1 && vec_o == 16'h0044, "R5 vector frozen", int'(vec_o), 16'h0044);
    do_read();
    @(negedge clk_i);
    chk(vec_o == 16'h0030, "R5 pending source 0 kept", int'(vec_o), 16'h0030);
    do_read();
    idle(2);

    // R2 level held high
    exp_q.push_back(vaddr(4));
    req_i[4] = 1'b1;
    wait_irq("R2 edge of source 4");
    do_read();
    idle(6);
    chk(irq_o == 0, "R2 held level not re-served", int'(irq_o), 0);
    req_i[4] = 1'b0;
    idle(2);

    // R7 masked source kept pending
    en_i[6] = 1'b0;
    pulse(11'b1 << 6);
    idle(6);
    chk(irq_o == 0, "R7 masked not presented", int'(irq_o), 0);
    exp_q.push_back(vaddr(6));
    en_i[6] = 1'b1;
    wait_irq("R7 enable presents kept bit");
    chk(vec_o == 16'h0048, "R7 vector of source 6", int'(vec_o), 16'h0048);
    do_read();
    idle(2);

    // R8 stray read while idle
    do_read();
    idle(2);
    chk(irq_o == 0, "R8 stray read irq", int'(irq_o), 0);
    chk(vec_o == 16'h0048, "R8 stray read vec", int'(vec_o), 16'h0048);
    exp_q.push_back(vaddr(1));
    pulse(11'b1 << 1);
    wait_irq("R8 later request served");
    chk(vec_o == 16'h0034, "R8 state intact", int'(vec_o), 16'h0034);
    do_read();
    idle(3);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule